// File: doc/BRIEF.md
# Programmable Serial Clock Edge Generator

This block derives the serial clock of a serial flash controller from the faster bus clock. A tick counter steps through a programmable period. Within that period, the tick on which SCK rises and the tick on which it falls can each be placed anywhere. A third tick position marks where read data should be captured. Besides the SCK level, the block emits two single-cycle strobes: one tells the shifter to drive the next output bit, the other tells the capture logic to sample input data.

Clocking starts when `enable` is seen high. After `enable` drops, the period in progress runs to its end, and SCK then rests high, as SPI mode 3 requires. New timing values can be loaded at any time. They take hold at the next period boundary, or on the next cycle if the generator is idle, so a period that has started is never distorted.

A driver that wants a plain divided clock with divider d (1 to 6) programs period 2·d, rise position d and fall position 0. This gives a clock with a 50 % duty cycle and a period of 2·d bus cycles.

Top module: `serclk_edge_gen`

## Requirements
- R1: After reset, `sck` is 1, both strobes are 0, and the generator is idle. The power-up timing is period 2, rise 1, fall 0, sample 1.
- R2: All outputs are registered. An event decided from tick count c appears on the outputs one bus cycle after the counter holds c.
- R3: While running, the counter counts 0 up to period−1 and then wraps. The count equal to the rise position drives `sck` to 1, and the count equal to the fall position drives it to 0. If both positions are equal, the rise wins. On every other count `sck` keeps its level.
- R4: `shiftStb` is a one-cycle pulse that comes out together with each falling edge of `sck`. It is not pulsed when the rise and fall positions coincide.
- R5: `sampleStb` is a one-cycle pulse on the count equal to the sample position, once in each running period.
- R6: A period value of 0 behaves as 1. Any rise, fall or sample position at or above the effective period is clamped to period−1.
- R7: When `enable` is sampled high while idle, count 0 of the first period starts on the next cycle.
- R8: When `enable` is low on the last tick of a period, the generator stops. From the next cycle on, `sck` is 1 and both strobes are 0, whatever `enable` does in the middle of a period.
- R9: A timing load (`cfgLoad` high) takes effect at the next period boundary: on the last tick of a running period, or on the next cycle while idle. Until then the current timing stays in use.
- R10: The divider setting (period 2·d, rise d, fall 0, sample d) gives `sck` low for d cycles and high for d cycles, with one shift strobe per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start or continue clocking; low stops at the end of the period |
| cfgLoad | input | 1 | Load the four timing fields |
| cfgPeriod | input | 4 | Period in bus-clock ticks (0 behaves as 1) |
| cfgRise | input | 4 | Tick of the rising edge |
| cfgFall | input | 4 | Tick of the falling edge |
| cfgSample | input | 4 | Tick of the read sampling strobe |
| sck | output | 1 | Serial clock, idle high |
| shiftStb | output | 1 | Shift-out strobe, one cycle, with each falling edge |
| sampleStb | output | 1 | Read sample strobe, one cycle |

## Verification
The embedded assertions check these properties on every cycle:
- the counter stays below the active period, and the active period is never 0;
- the active timing is never changed in the middle of a period;
- start and stop follow enable at the period boundary;
- SCK is high after an idle cycle;
- every falling edge of SCK carries a shift strobe, and every shift strobe sees SCK low;
- sample strobes occur only while running.

Only the bench's scenarios can show the exact tick on which each edge and strobe lands for a given timing. The same holds for the clamping of out-of-range positions, the divider duty cycle, and the period in which a reload becomes visible. The bench sweeps all sixteen periods against all sixteen rise positions and checks each of these cycle by cycle.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  localparam int FIELD_W = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] period;
    logic [FIELD_W-1:0] rise;
    logic [FIELD_W-1:0] fall;
    logic [FIELD_W-1:0] sample;
  } timing_t;

  // Strobes from control to datapath, decided from the current tick.
  typedef struct packed {
    logic running;
    logic riseHit;
    logic fallHit;
    logic sampleHit;
  } tick_ev_t;

  // Period 0 acts as 1; positions at or past the period clamp to period-1.
  function automatic timing_t normTiming(timing_t t);
    timing_t o;
    logic [FIELD_W-1:0] p;
    p        = (t.period == '0) ? FIELD_W'(1) : t.period;
    o.period = p;
    o.rise   = (t.rise   >= p) ? p - FIELD_W'(1) : t.rise;
    o.fall   = (t.fall   >= p) ? p - FIELD_W'(1) : t.fall;
    o.sample = (t.sample >= p) ? p - FIELD_W'(1) : t.sample;
    return o;
  endfunction

endpackage

// File: rtl/serclk_ctrl.sv
module serclk_ctrl
  import serclk_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DEF_PERIOD = FIELD_W'(2),
  parameter logic [FIELD_W-1:0] DEF_RISE   = FIELD_W'(1),
  parameter logic [FIELD_W-1:0] DEF_FALL   = FIELD_W'(0),
  parameter logic [FIELD_W-1:0] DEF_SAMPLE = FIELD_W'(1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     cfgLoad,
  input  timing_t  cfgIn,
  output tick_ev_t ev
);

  localparam timing_t DEF_CFG = '{period: DEF_PERIOD, rise: DEF_RISE,
                                  fall: DEF_FALL, sample: DEF_SAMPLE};

  timing_t            pendingCfg;
  timing_t            activeCfg;
  timing_t            nextPending;
  logic [FIELD_W-1:0] tickCnt;
  logic [FIELD_W-1:0] lastTick;
  logic               running;
  logic               atBoundary;

  assign nextPending = cfgLoad ? cfgIn : pendingCfg;
  assign lastTick    = activeCfg.period - FIELD_W'(1);
  assign atBoundary  = !running || (tickCnt == lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingCfg <= DEF_CFG;
      activeCfg  <= normTiming(DEF_CFG);
      tickCnt    <= '0;
      running    <= 1'b0;
    end else begin
      pendingCfg <= nextPending;
      if (atBoundary) activeCfg <= normTiming(nextPending);
      if (!running) begin
        tickCnt <= '0;
        running <= enable;
      end else if (tickCnt == lastTick) begin
        tickCnt <= '0;
        running <= enable;
      end else begin
        tickCnt <= tickCnt + FIELD_W'(1);
      end
    end
  end

  assign ev.running   = running;
  assign ev.riseHit   = running && (tickCnt == activeCfg.rise);
  assign ev.fallHit   = running && (tickCnt == activeCfg.fall);
  assign ev.sampleHit = running && (tickCnt == activeCfg.sample);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (tickCnt < activeCfg.period));

  // R6
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeCfg.period != '0);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && (tickCnt != lastTick)) |=> $stable(activeCfg));

  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && enable) |=> (running && (tickCnt == '0)));

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && (tickCnt == lastTick) && !enable) |=> !running);

endmodule

// File: rtl/serclk_dp.sv
module serclk_dp
  import serclk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  tick_ev_t ev,
  output logic     sck,
  output logic     shiftStb,
  output logic     sampleStb
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck       <= 1'b1;
      shiftStb  <= 1'b0;
      sampleStb <= 1'b0;
    end else if (!ev.running) begin
      sck       <= 1'b1;
      shiftStb  <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      if (ev.riseHit)      sck <= 1'b1;
      else if (ev.fallHit) sck <= 1'b0;
      shiftStb  <= ev.fallHit && !ev.riseHit;
      sampleStb <= ev.sampleHit;
    end
  end

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ev.running |=> sck);

  // R4
  shift_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftStb |-> !sck);

  // R4
  fall_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> shiftStb);

  // R5
  sample_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(ev.running));

endmodule

// File: rtl/serclk_edge_gen.sv
module serclk_edge_gen
  import serclk_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DEF_PERIOD = FIELD_W'(2),
  parameter logic [FIELD_W-1:0] DEF_RISE   = FIELD_W'(1),
  parameter logic [FIELD_W-1:0] DEF_FALL   = FIELD_W'(0),
  parameter logic [FIELD_W-1:0] DEF_SAMPLE = FIELD_W'(1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgLoad,
  input  logic [FIELD_W-1:0] cfgPeriod,
  input  logic [FIELD_W-1:0] cfgRise,
  input  logic [FIELD_W-1:0] cfgFall,
  input  logic [FIELD_W-1:0] cfgSample,
  output logic               sck,
  output logic               shiftStb,
  output logic               sampleStb
);

  timing_t  cfgIn;
  tick_ev_t ev;

  assign cfgIn = '{period: cfgPeriod, rise: cfgRise, fall: cfgFall, sample: cfgSample};

  serclk_ctrl #(
    .DEF_PERIOD(DEF_PERIOD),
    .DEF_RISE  (DEF_RISE),
    .DEF_FALL  (DEF_FALL),
    .DEF_SAMPLE(DEF_SAMPLE)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .cfgLoad(cfgLoad),
    .cfgIn  (cfgIn),
    .ev     (ev)
  );

  serclk_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ev       (ev),
    .sck      (sck),
    .shiftStb (shiftStb),
    .sampleStb(sampleStb)
  );

endmodule

// File: tb/test_serclk_edge_gen.sv
`timescale 1ns/1ps
module test_serclk_edge_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [3:0] cfgPeriod = '0, cfgRise = '0, cfgFall = '0, cfgSample = '0;
  logic       sck, shiftStb, sampleStb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench reference state
  int mP, mR, mF, mS, pP, pR, pF, pS, mCnt;
  bit mRun, eSck, eShift, eSample;

  always #2.5 clk = ~clk;

  serclk_edge_gen i_serclk_edge_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgLoad(cfgLoad),
    .cfgPeriod(cfgPeriod), .cfgRise(cfgRise), .cfgFall(cfgFall), .cfgSample(cfgSample),
    .sck(sck), .shiftStb(shiftStb), .sampleStb(sampleStb)
  );

  function automatic int clampPos(int per, int pos);
    return (pos >= per) ? per - 1 : pos;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // Advance the reference by one posedge with the given inputs.
  task automatic modelEdge(bit en, bit ld, int cp, int cr, int cf, int cs);
    bit bnd;
    int np;
    if (mRun) begin
      if (mCnt == mR) eSck = 1;
      else if (mCnt == mF) eSck = 0;
      eShift  = (mCnt == mF) && (mCnt != mR);
      eSample = (mCnt == mS);
    end else begin
      eSck = 1; eShift = 0; eSample = 0;
    end
    bnd = !mRun || (mCnt == mP - 1);
    if (ld) begin pP = cp; pR = cr; pF = cf; pS = cs; end
    if (!mRun) begin mCnt = 0; mRun = en; end
    else if (mCnt == mP - 1) begin mCnt = 0; mRun = en; end
    else mCnt++;
    if (bnd) begin
      np = (pP == 0) ? 1 : pP;
      mP = np; mR = clampPos(np, pR); mF = clampPos(np, pF); mS = clampPos(np, pS);
    end
  endtask

  // One bus cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(string tag, bit en, bit ld = 0, int cp = 0, int cr = 0,
                     int cf = 0, int cs = 0);
    enable = en; cfgLoad = ld;
    cfgPeriod = 4'(cp); cfgRise = 4'(cr); cfgFall = 4'(cf); cfgSample = 4'(cs);
    @(posedge clk);
    modelEdge(en, ld, cp, cr, cf, cs);
    @(negedge clk);
    check({tag, " sck"}, sck, eSck);
    check("R4 shiftStb", shiftStb, eShift);
    check("R5 sampleStb", sampleStb, eSample);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lowRun, highRun, shifts;
    mP = 2; mR = 1; mF = 0; mS = 1; pP = 2; pR = 1; pF = 0; pS = 1;
    mCnt = 0; mRun = 0; eSck = 1; eShift = 0; eSample = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sck", sck, 1'b1);
    check("R1 shiftStb", shiftStb, 1'b0);
    check("R1 sampleStb", sampleStb, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 default timing: run two periods with default config
    for (int i = 0; i < 5; i++) cyc("R1 R2", 1);
    for (int i = 0; i < 4; i++) cyc("R8", 0);

    // R10 divider settings d = 1..6, also measuring duty cycle
    for (int d = 1; d <= 6; d++) begin
      cyc("R9", 0, 1, 2*d, d, 0, d);
      cyc("R7", 1);
      lowRun = 0; highRun = 0; shifts = 0;
      for (int i = 0; i < 6*d; i++) begin
        cyc("R10", 1);
        if (i >= 2*d && i < 4*d) begin
          if (sck) highRun++; else lowRun++;
          if (shiftStb) shifts++;
        end
      end
      checks++;
      if (lowRun != d || highRun != d || shifts != 1) begin
        errors++;
        $display("FAIL R10 d=%0d: actual low %0d high %0d shifts %0d expected %0d %0d 1",
                 d, lowRun, highRun, shifts, d, d);
      end
      for (int i = 0; i < 2*d + 3; i++) cyc("R8", 0);
    end

    // R3 R6 sweep of periods against rise positions (includes period 0 and clamping)
    for (int p = 0; p < 16; p++) begin
      for (int r = 0; r < 16; r++) begin
        int pe;
        pe = (p == 0) ? 1 : p;
        cyc("R6", 0, 1, p, r, (r + p/2 + 1) % 16, 15 - r);
        for (int i = 0; i < 2*pe + 1; i++) cyc("R3 R6", 1);
        for (int i = 0; i < pe + 2; i++) cyc("R8", 0);
      end
    end

    // R9 reload while running, both mid-period and on the last tick
    cyc("R9", 0, 1, 8, 4, 0, 6);
    for (int i = 0; i < 3; i++) cyc("R9", 1);
    cyc("R9", 1, 1, 5, 1, 3, 2);
    for (int i = 0; i < 12; i++) cyc("R9", 1);
    cyc("R9", 1, 1, 3, 2, 0, 9);
    for (int i = 0; i < 12; i++) cyc("R9", 1);
    for (int i = 0; i < 8; i++) cyc("R8", 0);

    // R7 R8 single-cycle enable pulse still runs one whole period
    cyc("R9", 0, 1, 7, 5, 2, 3);
    cyc("R7", 1);
    for (int i = 0; i < 10; i++) cyc("R8", 0);
    // R8 enable toggling mid-period does not cut the period short
    cyc("R7", 1);
    cyc("R8", 0);
    cyc("R8", 1);
    for (int i = 0; i < 16; i++) cyc("R8", 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule